// File: doc/BRIEF.md
# Custom-Instruction Interrupt Controller

This unit sits beside the execute stage of a small 32-bit RISC-V style core and handles interrupts through a handful of custom instructions rather than control/status registers. It keeps four 32-bit shadow registers, a 32-bit mask, a 32-bit sticky pending register and a global enable flag. The core presents each instruction word with an issue strobe, the source-register value and the current program counter. The unit answers with a destination-register write, a program-counter redirect, an illegal-instruction pulse, a stall level and a sticky trap flag.

Shadow register 0 receives the return address on interrupt entry. Shadow register 1 receives the set of interrupts being delivered. Shadow registers 2 and 3 are scratch space for the handler and are not cleared by reset. Interrupt line 1 is the misaligned/illegal-instruction trap line. If that line becomes pending while it cannot be delivered, the processor halts: the unit raises a sticky trap flag and holds the core stalled.

Every result is registered, so it appears on the outputs one clock after the cycle that caused it.

Top module: `irq_ctrl_unit`

## Requirements
- R1: An instruction is recognised only when `issue_i` is high, instruction bits 6:0 equal 0001011, bits 14:12 are 000 and bits 24:20 are 00000. Bits 31:25 then select the operation: 0 getq, 1 setq, 2 retirq, 3 maskirq, 4 waitirq. Instructions with any other value in bits 6:0 produce no output and change no state. At most one of `rd_we_o`, `redirect_o` and `illegal_o` is high in any cycle.
- R2: getq requires rs1 field bits 19:17 to be zero. It writes shadow register rs1[1:0] to the destination index rd (bits 11:7) one cycle after issue.
- R3: setq requires rd field bits 11:9 to be zero. It copies `rs_val_i` into shadow register rd[1:0].
- R4: maskirq loads `rs_val_i` into the mask and writes the previous mask to rd. A mask bit of 1 blocks delivery of that line.
- R5: A pending bit is set by a high request line and stays set until that bit is delivered. Entry happens only when interrupts are enabled, at least one pending bit is unmasked, no instruction is issued in that cycle and the unit is neither waiting nor trapped.
- R6: On entry, the unit stores `pc_i` in shadow register 0 and stores every unmasked pending bit, possibly several, in shadow register 1. It clears those pending bits, disables interrupts and pulses `redirect_o` with `redirect_pc_o` = HANDLER_ADDR one cycle later.
- R7: retirq (rs1 and rd fields zero) pulses `redirect_o` with shadow register 0 as target and re-enables interrupts.
- R8: waitirq with no pending bit raises `stall_o` until some pending bit (masked or not) is present. In the cycle after one is present, it writes the pending bitmask to rd and drops `stall_o`. If a bit is already pending at issue, the result follows in one cycle with no stall.
- R9: Under opcode 0001011, any of the following pulses `illegal_o` one cycle later and modifies no register: an undefined bits 31:25 value, a non-zero bits 14:12, a non-zero bits 24:20, or a violated field-zero rule of R2, R3 or R7.
- R10: When interrupt line 1 is pending while interrupts are disabled or line 1 is masked, `trap_o` rises and stays high until reset. `stall_o` is held high, and issued instructions are then ignored.
- R11: After reset, interrupts are enabled, the mask is 0, nothing is pending, shadow registers 0 and 1 are 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the source register |
| pc_i | input | 32 | Current program counter, used as return address |
| irq_i | input | 32 | Interrupt request lines |
| rd_we_o | output | 1 | Destination-register write strobe |
| rd_idx_o | output | 5 | Destination-register index |
| rd_val_o | output | 32 | Destination-register value |
| redirect_o | output | 1 | Program-counter redirect strobe |
| redirect_pc_o | output | 32 | Redirect target |
| stall_o | output | 1 | Core must hold (waiting or trapped) |
| illegal_o | output | 1 | Illegal custom instruction pulse |
| trap_o | output | 1 | Sticky halt flag from line 1 |

## Verification
Entry is driven with a request pattern that mixes a masked line and an unmasked line. The delivered set must then contain only the unmasked bit, while the masked bit stays pending. A later two-line burst, raised while interrupts are disabled, tells apart a controller that delivers the whole pending set from one that delivers a single line. It also shows that nothing is delivered before retirq. Wait-for-interrupt is tried both with an empty and with a pre-loaded pending register, which separates the stalling path from the immediate path. Malformed custom words, a foreign opcode and line 1 raised while masked each show whether the state is left untouched or the trap fires.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int ILEN  = 32;
    localparam int FLD_W = 5;
    localparam int OPC_W = 7;
    localparam int F3_W  = 3;
    localparam int F7_W  = 7;

    localparam logic [OPC_W-1:0] OPC_CUSTOM0 = 7'b0001011;

    localparam logic [F7_W-1:0] F7_GETQ    = 7'd0;
    localparam logic [F7_W-1:0] F7_SETQ    = 7'd1;
    localparam logic [F7_W-1:0] F7_RETIRQ  = 7'd2;
    localparam logic [F7_W-1:0] F7_MASKIRQ = 7'd3;
    localparam logic [F7_W-1:0] F7_WAITIRQ = 7'd4;

    typedef enum logic [2:0] {
        OP_GETQ    = 3'd0,
        OP_SETQ    = 3'd1,
        OP_RETIRQ  = 3'd2,
        OP_MASKIRQ = 3'd3,
        OP_WAITIRQ = 3'd4,
        OP_NONE    = 3'd7
    } irq_op_e;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        irq_op_e          op;
        logic [FLD_W-1:0] rd;
    } dec_t;

endpackage

// File: rtl/irq_decode.sv
module irq_decode
    import irq_ctrl_pkg::*;
#(
    parameter int QW = 2
) (
    input  logic            issue_i,
    input  logic [ILEN-1:0] instr_i,
    output dec_t            dec_o,
    output logic [QW-1:0]   qsel_o
);

    logic [F7_W-1:0]  f7;
    logic [FLD_W-1:0] rs2_f;
    logic [FLD_W-1:0] rs1_f;
    logic [F3_W-1:0]  f3;
    logic [FLD_W-1:0] rd_f;
    logic [OPC_W-1:0] opc;

    assign f7    = instr_i[31:25];
    assign rs2_f = instr_i[24:20];
    assign rs1_f = instr_i[19:15];
    assign f3    = instr_i[14:12];
    assign rd_f  = instr_i[11:7];
    assign opc   = instr_i[6:0];

    always_comb begin
        dec_o.valid   = 1'b0;
        dec_o.illegal = 1'b0;
        dec_o.op      = OP_NONE;
        dec_o.rd      = rd_f;
        qsel_o        = '0;
        if (issue_i && opc == OPC_CUSTOM0) begin
            dec_o.illegal = 1'b1;
            if (f3 == '0 && rs2_f == '0) begin
                case (f7)
                    F7_GETQ: begin
                        if ((rs1_f >> QW) == '0) begin
                            dec_o.valid   = 1'b1;
                            dec_o.illegal = 1'b0;
                            dec_o.op      = OP_GETQ;
                            qsel_o        = rs1_f[QW-1:0];
                        end
                    end
                    F7_SETQ: begin
                        if ((rd_f >> QW) == '0) begin
                            dec_o.valid   = 1'b1;
                            dec_o.illegal = 1'b0;
                            dec_o.op      = OP_SETQ;
                            qsel_o        = rd_f[QW-1:0];
                        end
                    end
                    F7_RETIRQ: begin
                        if (rs1_f == '0 && rd_f == '0) begin
                            dec_o.valid   = 1'b1;
                            dec_o.illegal = 1'b0;
                            dec_o.op      = OP_RETIRQ;
                        end
                    end
                    F7_MASKIRQ: begin
                        dec_o.valid   = 1'b1;
                        dec_o.illegal = 1'b0;
                        dec_o.op      = OP_MASKIRQ;
                    end
                    F7_WAITIRQ: begin
                        dec_o.valid   = 1'b1;
                        dec_o.illegal = 1'b0;
                        dec_o.op      = OP_WAITIRQ;
                    end
                    default: begin
                        dec_o.illegal = 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
    parameter int NIRQ      = 32,
    parameter int TRAP_LINE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_i,
    input  logic [NIRQ-1:0] clr_i,
    input  logic            en_i,
    input  logic [NIRQ-1:0] mask_i,
    output logic [NIRQ-1:0] pend_o,
    output logic            trap_o
);

    typedef struct packed {
        logic [NIRQ-1:0] pend;
        logic            trap;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_i) | irq_i;
        st_d.trap = st_q.trap |
                    (st_q.pend[TRAP_LINE] & (~en_i | mask_i[TRAP_LINE]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign trap_o = st_q.trap;

    // R10: the halt flag never falls without reset
    assert_trap_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> trap_o);

    // R5: with nothing delivered, no pending bit is lost
    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
    import irq_ctrl_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          NIRQ         = 32,
    parameter int          NQ           = 4,
    parameter int          TRAP_LINE    = 1,
    parameter logic [31:0] HANDLER_ADDR = 32'h0000_0010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [ILEN-1:0] instr_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [NIRQ-1:0] irq_i,
    output logic            rd_we_o,
    output logic [FLD_W-1:0] rd_idx_o,
    output logic [XLEN-1:0] rd_val_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            stall_o,
    output logic            illegal_o,
    output logic            trap_o
);

    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

    typedef struct packed {
        logic             en;
        logic [NIRQ-1:0]  mask;
        logic             waiting;
        logic [FLD_W-1:0] wait_rd;
        logic             rd_we;
        logic [FLD_W-1:0] rd_idx;
        logic [XLEN-1:0]  rd_val;
        logic             redir;
        logic [XLEN-1:0]  redir_pc;
        logic             illegal;
    } st_t;

    st_t s_d, s_q;

    logic [NQ-1:0][XLEN-1:0] q_d, q_q;

    dec_t            dec;
    logic [QW-1:0]   qsel;
    logic [NIRQ-1:0] pend;
    logic [NIRQ-1:0] unmasked;
    logic [NIRQ-1:0] clr;
    logic            trapped;
    logic            active;
    logic            take;
    logic            do_ret;

    irq_decode #(.QW(QW)) u_dec (
        .issue_i (issue_i),
        .instr_i (instr_i),
        .dec_o   (dec),
        .qsel_o  (qsel)
    );

    irq_pend_track #(.NIRQ(NIRQ), .TRAP_LINE(TRAP_LINE)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq_i),
        .clr_i  (clr),
        .en_i   (s_q.en),
        .mask_i (s_q.mask),
        .pend_o (pend),
        .trap_o (trapped)
    );

    assign active   = !s_q.waiting && !trapped;
    assign unmasked = pend & ~s_q.mask;
    assign take     = active && s_q.en && (|unmasked) && !issue_i;
    assign clr      = take ? unmasked : '0;
    assign do_ret   = active && dec.valid && dec.op == OP_RETIRQ;

    always_comb begin
        s_d         = s_q;
        s_d.rd_we   = 1'b0;
        s_d.redir   = 1'b0;
        s_d.illegal = 1'b0;
        q_d         = q_q;
        if (s_q.waiting && !trapped) begin
            if (|pend) begin
                s_d.rd_we   = 1'b1;
                s_d.rd_idx  = s_q.wait_rd;
                s_d.rd_val  = XLEN'(pend);
                s_d.waiting = 1'b0;
            end
        end else if (active && dec.illegal) begin
            s_d.illegal = 1'b1;
        end else if (active && dec.valid) begin
            case (dec.op)
                OP_GETQ: begin
                    s_d.rd_we  = 1'b1;
                    s_d.rd_idx = dec.rd;
                    s_d.rd_val = q_q[qsel];
                end
                OP_SETQ: begin
                    q_d[qsel] = rs_val_i;
                end
                OP_RETIRQ: begin
                    s_d.redir    = 1'b1;
                    s_d.redir_pc = q_q[0];
                    s_d.en       = 1'b1;
                end
                OP_MASKIRQ: begin
                    s_d.mask   = rs_val_i[NIRQ-1:0];
                    s_d.rd_we  = 1'b1;
                    s_d.rd_idx = dec.rd;
                    s_d.rd_val = XLEN'(s_q.mask);
                end
                OP_WAITIRQ: begin
                    if (|pend) begin
                        s_d.rd_we  = 1'b1;
                        s_d.rd_idx = dec.rd;
                        s_d.rd_val = XLEN'(pend);
                    end else begin
                        s_d.waiting = 1'b1;
                        s_d.wait_rd = dec.rd;
                    end
                end
                default: begin
                    s_d.illegal = 1'b1;
                end
            endcase
        end else if (take) begin
            q_d[0]       = pc_i;
            q_d[1]       = XLEN'(unmasked);
            s_d.en       = 1'b0;
            s_d.redir    = 1'b1;
            s_d.redir_pc = XLEN'(HANDLER_ADDR);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.en <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // shadow bank: entries 0 and 1 are reset, the rest are scratch
    for (genvar gi = 0; gi < NQ; gi++) begin : g_qreg
        logic [XLEN-1:0] r_q;
        if (gi < 2) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_q <= '0;
                end else begin
                    r_q <= q_d[gi];
                end
            end
        end else begin : g_scratch
            always_ff @(posedge clk) begin
                r_q <= q_d[gi];
            end
        end
        assign q_q[gi] = r_q;
    end

    assign rd_we_o       = s_q.rd_we;
    assign rd_idx_o      = s_q.rd_idx;
    assign rd_val_o      = s_q.rd_val;
    assign redirect_o    = s_q.redir;
    assign redirect_pc_o = s_q.redir_pc;
    assign illegal_o     = s_q.illegal;
    assign stall_o       = s_q.waiting | trapped;
    assign trap_o        = trapped;

    // R1: one kind of result per cycle
    assert_one_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_we_o, redirect_o, illegal_o}));

    // R6: entry disables interrupts and jumps to the handler
    assert_entry_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!s_q.en && redirect_o && redirect_pc_o == XLEN'(HANDLER_ADDR)));

    // R7: return jumps to the saved address and re-enables
    assert_return_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        do_ret |=> (s_q.en && redirect_o && redirect_pc_o == $past(q_q[0])));

    // R9: an illegal word leaves mask and enable untouched
    assert_illegal_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && dec.illegal) |=> ($stable(s_q.mask) && $stable(s_q.en) && illegal_o));

    // R10: a trapped unit keeps the core stalled
    assert_trap_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> stall_o);

endmodule

// File: tb/tb_irq_ctrl_unit.sv
`timescale 1ns/1ps
module tb_irq_ctrl_unit;

    localparam logic [31:0] HANDLER = 32'h0000_0010;
    localparam logic [6:0]  C0      = 7'b0001011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] pc_i = 32'h100;
    logic [31:0] irq_i = '0;
    logic        rd_we_o;
    logic [4:0]  rd_idx_o;
    logic [31:0] rd_val_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;
    logic        stall_o;
    logic        illegal_o;
    logic        trap_o;

    irq_ctrl_unit #(.HANDLER_ADDR(HANDLER)) dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
        .rs_val_i(rs_val_i), .pc_i(pc_i), .irq_i(irq_i),
        .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o), .rd_val_o(rd_val_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .stall_o(stall_o), .illegal_o(illegal_o), .trap_o(trap_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          kind;
        logic [4:0]  idx;
        logic [31:0] val;
        string       req;
    } ev_t;

    ev_t   exp_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string quiet_req = "R1";

    function automatic logic [31:0] mk(logic [6:0] f7, logic [4:0] rs1,
                                       logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
        return {f7, 5'd0, rs1, f3, rd, opc};
    endfunction

    task automatic push(int kind, logic [4:0] idx, logic [31:0] val, string req);
        ev_t e;
        e.kind = kind; e.idx = idx; e.val = val; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic compare(int kind, logic [4:0] idx, logic [31:0] val);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL %s unexpected output kind=%0d idx=%0d val=%h expected none",
                     quiet_req, kind, idx, val);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.idx != idx || e.val != val) begin
                failures++;
                $display("FAIL %s actual kind=%0d idx=%0d val=%h expected kind=%0d idx=%0d val=%h",
                         e.req, kind, idx, val, e.kind, e.idx, e.val);
            end
        end
    endtask

    // monitor: compares each result pulse with the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (rd_we_o)    compare(0, rd_idx_o, rd_val_o);
            if (redirect_o) compare(1, 5'd0, redirect_pc_o);
            if (illegal_o)  compare(2, 5'd0, 32'd0);
        end
    end

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] ins, logic [31:0] rs);
        @(negedge clk);
        issue_i  = 1'b1;
        instr_i  = ins;
        rs_val_i = rs;
        @(negedge clk);
        issue_i  = 1'b0;
        instr_i  = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_irq(logic [31:0] lines);
        @(negedge clk);
        irq_i = lines;
        @(negedge clk);
        irq_i = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check_eq("R11 rd_we", {31'd0, rd_we_o}, 32'd0);
        check_eq("R11 redirect", {31'd0, redirect_o}, 32'd0);
        check_eq("R11 illegal", {31'd0, illegal_o}, 32'd0);
        check_eq("R11 stall", {31'd0, stall_o}, 32'd0);
        check_eq("R11 trap", {31'd0, trap_o}, 32'd0);
        mon_on = 1'b1;

        // R3 setq then R2 getq of scratch registers
        issue(mk(7'd1, 5'd9, 3'd0, 5'd2, C0), 32'hA5A5_0002);
        issue(mk(7'd1, 5'd9, 3'd0, 5'd3, C0), 32'h0000_3333);
        push(0, 5'd5, 32'hA5A5_0002, "R2 R3 getq q2");
        issue(mk(7'd0, 5'd2, 3'd0, 5'd5, C0), 32'h0);
        push(0, 5'd6, 32'h0000_3333, "R2 R3 getq q3");
        issue(mk(7'd0, 5'd3, 3'd0, 5'd6, C0), 32'h0);

        // R4 maskirq returns old mask (R11 reset mask 0)
        push(0, 5'd7, 32'h0, "R4 R11 first maskirq");
        issue(mk(7'd3, 5'd1, 3'd0, 5'd7, C0), 32'h0000_00F0);
        push(0, 5'd8, 32'h0000_00F0, "R4 second maskirq");
        issue(mk(7'd3, 5'd1, 3'd0, 5'd8, C0), 32'h0000_0010);

        // R5 R6 entry with one masked and one unmasked line
        quiet_req = "R5";
        push(1, 5'd0, HANDLER, "R6 entry redirect");
        pulse_irq(32'h0000_0014);
        idle(3);
        push(0, 5'd9, 32'h0000_0100, "R6 q0 return address");
        issue(mk(7'd0, 5'd0, 3'd0, 5'd9, C0), 32'h0);
        push(0, 5'd10, 32'h0000_0004, "R4 R6 q1 only unmasked bit");
        issue(mk(7'd0, 5'd1, 3'd0, 5'd10, C0), 32'h0);

        // disabled: unmasking and new requests deliver nothing
        push(0, 5'd11, 32'h0000_0010, "R4 unmask");
        issue(mk(7'd3, 5'd0, 3'd0, 5'd11, C0), 32'h0);
        idle(4);
        pulse_irq(32'h0000_0028);
        idle(3);

        // R7 return, then R6 entry delivering several bits
        pc_i = 32'h0000_0200;
        push(1, 5'd0, 32'h0000_0100, "R7 retirq target");
        push(1, 5'd0, HANDLER, "R5 R6 entry after retirq");
        issue(mk(7'd2, 5'd0, 3'd0, 5'd0, C0), 32'h0);
        idle(3);
        push(0, 5'd14, 32'h0000_0038, "R6 multi-bit q1");
        issue(mk(7'd0, 5'd1, 3'd0, 5'd14, C0), 32'h0);
        push(0, 5'd15, 32'h0000_0200, "R6 q0 second entry");
        issue(mk(7'd0, 5'd0, 3'd0, 5'd15, C0), 32'h0);

        // R9 illegal forms leave state alone
        quiet_req = "R9";
        push(2, 5'd0, 32'h0, "R9 undefined funct7");
        issue(mk(7'd5, 5'd0, 3'd0, 5'd0, C0), 32'h0000_DEAD);
        push(2, 5'd0, 32'h0, "R9 nonzero funct3 setq");
        issue(mk(7'd1, 5'd0, 3'd1, 5'd0, C0), 32'h0000_DEAD);
        push(2, 5'd0, 32'h0, "R1 R9 getq high rs1 bit");
        issue(mk(7'd0, 5'd4, 3'd0, 5'd3, C0), 32'h0);
        push(0, 5'd16, 32'h0000_0200, "R9 q0 unchanged");
        issue(mk(7'd0, 5'd0, 3'd0, 5'd16, C0), 32'h0);
        quiet_req = "R1";
        issue(mk(7'd1, 5'd0, 3'd0, 5'd0, 7'h33), 32'h0000_BEEF);
        push(0, 5'd17, 32'h0000_0200, "R1 foreign opcode ignored");
        issue(mk(7'd0, 5'd0, 3'd0, 5'd17, C0), 32'h0);

        // R8 waitirq with empty pending register
        push(0, 5'd18, 32'h0, "R4 mask all but line 1");
        issue(mk(7'd3, 5'd0, 3'd0, 5'd18, C0), 32'hFFFF_FFFD);
        quiet_req = "R8";
        issue(mk(7'd4, 5'd0, 3'd0, 5'd12, C0), 32'h0);
        check_eq("R8 stall while waiting", {31'd0, stall_o}, 32'd1);
        idle(2);
        check_eq("R8 still stalled", {31'd0, stall_o}, 32'd1);
        push(0, 5'd12, 32'h0000_0080, "R8 wait result");
        pulse_irq(32'h0000_0080);
        idle(2);
        check_eq("R8 stall released", {31'd0, stall_o}, 32'd0);
        // R8 waitirq with a bit already pending
        push(0, 5'd13, 32'h0000_0080, "R8 immediate wait result");
        issue(mk(7'd4, 5'd0, 3'd0, 5'd13, C0), 32'h0);
        check_eq("R8 no stall when pending", {31'd0, stall_o}, 32'd0);

        // R10 line 1 raised while masked halts
        push(0, 5'd19, 32'hFFFF_FFFD, "R4 mask everything");
        issue(mk(7'd3, 5'd0, 3'd0, 5'd19, C0), 32'hFFFF_FFFF);
        quiet_req = "R10";
        pulse_irq(32'h0000_0002);
        idle(3);
        check_eq("R10 trap raised", {31'd0, trap_o}, 32'd1);
        check_eq("R10 stall on trap", {31'd0, stall_o}, 32'd1);
        issue(mk(7'd0, 5'd0, 3'd0, 5'd20, C0), 32'h0);
        idle(5);
        check_eq("R10 trap sticky", {31'd0, trap_o}, 32'd1);
        idle(4);

        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s missing results actual=%0d expected=0", exp_q[0].req, exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule